// File: doc/BRIEF.md
# Serial-Loaded Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable ratio N from 256 to 8191. N is loaded over a three-wire serial port: a data line, a shift clock and an enable. The serial word is 16 bits. Its low 13 bits carry the bitwise complement of N and its top 3 bits select one of the band outputs. Each band output is active low. While the enable is high, each falling edge of the shift clock moves one bit into a shift register. While the enable is low, a holding latch follows that register, and the latch sets the ratio and the band outputs.

The divider has a prescaler that divides by 16 or by 17, a 4-bit swallow counter and a 9-bit main counter. In each output cycle the prescaler runs at 17 for N mod 16 periods and at 16 for the remaining periods. The main counter counts N div 16 prescaler periods, so every output cycle is exactly N input clocks long. A new ratio is taken only at a terminal count. A latched ratio below 256 is raised to 256. The serial lines are asynchronous to the input clock: they pass through synchronizers, and the whole block runs on the input clock.

Top module: `dsd_synth_div`

## Requirements
- R1: After reset all band outputs are high and the divider runs at ratio 256, until a word is loaded.
- R2: A word is 16 serial bits. The first 13 bits are the complement of N, least significant bit first. The next 3 bits are band bits 0, 1 and 2. A bit is taken on a falling edge of ser_clk only while ser_en is high.
- R3: Falling edges of ser_clk while ser_en is low change neither the ratio nor the band outputs.
- R4: While ser_en is high, the ratio and the band outputs keep the last latched value, even partway through a word.
- R5: For a latched N from 256 to 8191, carry_tp pulses exactly once every N input clock cycles.
- R6: div_out is high for exactly the last 16 input cycles of each output cycle. It is low in the cycle after a carry_tp pulse.
- R7: A ratio latched partway through an output cycle does not change that cycle. It governs the next output cycle.
- R8: A latched N below 256 gives an output period of 256 cycles.
- R9: band_n[i] is the inverse of latched band bit i. Band bit i is serial bit 14+i, counting from 1.
- R10: carry_tp is never high for two consecutive input cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock, sampled on its falling edge |
| ser_en | input | 1 | High: shifting allowed; low: latch follows the shift register |
| div_out | output | 1 | Divided output, high for the final 16 input cycles of each period |
| carry_tp | output | 1 | Divider terminal-count test pulse, one cycle per period |
| band_n | output | 3 | Active-low band select outputs |

## Verification
A serial bit enters the shift register three input cycles after its ser_clk fall: two synchronizer stages and then the shift stage. The latch follows the register three cycles after ser_en falls. The ratio then waits for the next terminal count. So the bench gives each serial phase four input cycles, and it measures a ratio only in the third period after a load, when an old period can no longer be in progress. carry_tp is high in the last input cycle of a period, and div_out falls one cycle later. The bench counts falling edges of clk between carry pulses, and it counts high div_out samples in the same window. The mid-cycle test drops ser_en twenty cycles after a carry. The period in progress must then be the old one, and the one after it the new one.

// File: rtl/dsd_pkg.sv
// Package: default sizes and the prescaler modulus type for the divider.
// Assumes: the prescaler is a power of two (2**PRE_W) with one extra count.
package dsd_pkg;
    localparam int unsigned DSD_RATIO_W = 13;
    localparam int unsigned DSD_BAND_W  = 3;
    localparam int unsigned DSD_PRE_W   = 4;
    localparam int unsigned DSD_SYNC    = 2;

    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_EXTRA = 1'b1
    } mod_e;
endpackage

// File: rtl/dsd_sync.sv
// Module: multi-bit, multi-stage synchronizer for slow asynchronous lines.
// Assumes: each bit is independent and changes slowly relative to clk.
module dsd_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) st[0] <= '0;
                    else        st[0] <= d;
                end
            end else begin : g_next
                // Purpose: settle the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) st[s] <= '0;
                    else        st[s] <= st[s-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/dsd_loader.sv
// Module: serial word receiver with shift register and holding latch.
// Shifts on synchronized falling edges of ser_clk while enable is high; the
// latch follows the shift register whenever enable is low.
// Assumes: each ser_clk phase lasts longer than SYNC_STAGES+1 clk cycles.
module dsd_loader #(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned RATIO_W     = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_en,
    output logic [WORD_W-1:0] word_q,
    output logic              en_sync
);
    // Reset word: ratio field all ones (N = 0, clamped later), band bits clear.
    localparam logic [WORD_W-1:0] WORD_RST =
        {{(WORD_W-RATIO_W){1'b0}}, {RATIO_W{1'b1}}};

    logic [2:0]        raw;
    logic [2:0]        synced;
    logic              data_s;
    logic              sclk_s;
    logic              sclk_d;
    logic              sclk_fall;
    logic [WORD_W-1:0] shift_q;

    assign raw = {ser_data, ser_clk, ser_en};

    dsd_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
    );

    assign data_s  = synced[2];
    assign sclk_s  = synced[1];
    assign en_sync = synced[0];

    // Purpose: remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_fall = sclk_d & ~sclk_s;

    // Purpose: shift new bits in at the top so the first bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                   shift_q <= WORD_RST;
        else if (sclk_fall && en_sync) shift_q <= {data_s, shift_q[WORD_W-1:1]};
    end

    // Purpose: holding latch, transparent while enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= WORD_RST;
        else if (!en_sync) word_q <= shift_q;
    end
endmodule

// File: rtl/dsd_ratio.sv
// Module: decodes the latched complement into a clamped ratio and splits it
// into swallow (low PRE_W bits) and main (upper bits) counter loads.
// Assumes: RATIO_W > 2*PRE_W so the minimum ratio is representable.
module dsd_ratio #(
    parameter int unsigned RATIO_W = 13,
    parameter int unsigned PRE_W   = 4
) (
    input  logic [RATIO_W-1:0]       ratio_cpl,
    output logic [PRE_W-1:0]         swallow_ld,
    output logic [RATIO_W-PRE_W-1:0] main_ld
);
    localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(1 << (2*PRE_W));

    logic [RATIO_W-1:0] n_raw;
    logic [RATIO_W-1:0] n_eff;

    // Purpose: undo the complement and enforce the lowest continuous ratio.
    always_comb begin
        n_raw = ~ratio_cpl;
        n_eff = (n_raw < MIN_RATIO) ? MIN_RATIO : n_raw;
    end

    assign swallow_ld = n_eff[PRE_W-1:0];
    assign main_ld    = n_eff[RATIO_W-1:PRE_W];
endmodule

// File: rtl/dsd_core.sv
// Module: dual-modulus divider core. The prescaler counts 2**PRE_W input
// cycles, or one more while the swallow counter is nonzero. The main counter
// counts prescaler periods. Both reload at the terminal count only.
// Assumes: main_ld >= 2**PRE_W, so the swallow count always runs out first.
module dsd_core #(
    parameter int unsigned PRE_W  = 4,
    parameter int unsigned MAIN_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  swallow_ld,
    input  logic [MAIN_W-1:0] main_ld,
    output logic              div_out,
    output logic              carry
);
    import dsd_pkg::*;

    localparam int unsigned       PC_W      = PRE_W + 1;
    localparam logic [PC_W-1:0]   END_BASE  = PC_W'((1 << PRE_W) - 1);
    localparam logic [PC_W-1:0]   END_EXTRA = PC_W'(1 << PRE_W);
    localparam logic [MAIN_W-1:0] MAIN_RST  = MAIN_W'(1 << PRE_W);
    localparam logic [MAIN_W-1:0] MAIN_LAST = MAIN_W'(1);

    logic [PC_W-1:0]   pc_q;
    logic [PRE_W-1:0]  sw_q;
    logic [MAIN_W-1:0] mn_q;
    mod_e              mode;
    logic [PC_W-1:0]   pc_end;
    logic              period_end;
    logic              last_period;

    // Purpose: choose modulus 17 while swallow counts remain.
    always_comb begin
        mode        = (sw_q != '0) ? MOD_EXTRA : MOD_BASE;
        pc_end      = (mode == MOD_EXTRA) ? END_EXTRA : END_BASE;
        period_end  = (pc_q == pc_end);
        last_period = (mn_q == MAIN_LAST);
    end

    // Purpose: prescaler count within one prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= '0;
        else if (period_end) pc_q <= '0;
        else                 pc_q <= pc_q + PC_W'(1);
    end

    // Purpose: swallow and main counters, reloaded at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
            mn_q <= MAIN_RST;
        end else if (period_end) begin
            if (last_period) begin
                sw_q <= swallow_ld;
                mn_q <= main_ld;
            end else begin
                mn_q <= mn_q - MAIN_W'(1);
                if (mode == MOD_EXTRA) sw_q <= sw_q - PRE_W'(1);
            end
        end
    end

    assign carry   = period_end & last_period;
    assign div_out = last_period;
endmodule

// File: rtl/dsd_synth_div.sv
// Module: top of the serial-loaded dual-modulus divider.
// Assumes: serial lines are asynchronous and slow; clk is the fast input.
module dsd_synth_div #(
    parameter int unsigned RATIO_W     = dsd_pkg::DSD_RATIO_W,
    parameter int unsigned BAND_W      = dsd_pkg::DSD_BAND_W,
    parameter int unsigned PRE_W       = dsd_pkg::DSD_PRE_W,
    parameter int unsigned SYNC_STAGES = dsd_pkg::DSD_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_en,
    output logic              div_out,
    output logic              carry_tp,
    output logic [BAND_W-1:0] band_n
);
    localparam int unsigned WORD_W = RATIO_W + BAND_W;
    localparam int unsigned MAIN_W = RATIO_W - PRE_W;

    logic [WORD_W-1:0] word_q;
    logic              en_sync;
    logic [PRE_W-1:0]  swallow_ld;
    logic [MAIN_W-1:0] main_ld;

    dsd_loader #(
        .WORD_W      (WORD_W),
        .RATIO_W     (RATIO_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_en   (ser_en),
        .word_q   (word_q),
        .en_sync  (en_sync)
    );

    dsd_ratio #(.RATIO_W(RATIO_W), .PRE_W(PRE_W)) u_ratio (
        .ratio_cpl  (word_q[RATIO_W-1:0]),
        .swallow_ld (swallow_ld),
        .main_ld    (main_ld)
    );

    dsd_core #(.PRE_W(PRE_W), .MAIN_W(MAIN_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .swallow_ld (swallow_ld),
        .main_ld    (main_ld),
        .div_out    (div_out),
        .carry      (carry_tp)
    );

    generate
        for (genvar b = 0; b < BAND_W; b++) begin : g_band
            assign band_n[b] = ~word_q[RATIO_W+b];
        end
    endgenerate
endmodule

// File: rtl/dsd_checker.sv
// Module: property checker bound to the divider top.
// Assumes: en_sync is the synchronized enable seen by the latch.
module dsd_checker #(
    parameter int unsigned RATIO_W = 13,
    parameter int unsigned BAND_W  = 3,
    parameter int unsigned PRE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              carry_tp,
    input logic              div_out,
    input logic [BAND_W-1:0] band_n,
    input logic              en_sync
);
    localparam logic [RATIO_W:0] MAX_GAP = (RATIO_W+1)'((1 << RATIO_W) - 2);
    localparam logic [RATIO_W:0] MIN_GAP = (RATIO_W+1)'((1 << (2*PRE_W)) - 1);

    logic [RATIO_W:0] gap_q;

    // Purpose: cycles elapsed since the last carry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap_q <= '0;
        else if (carry_tp) gap_q <= '0;
        else               gap_q <= gap_q + (RATIO_W+1)'(1);
    end

    assert_gap_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= MAX_GAP);

    assert_gap_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_tp |-> (gap_q >= MIN_GAP));

    assert_carry_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_tp |=> !carry_tp);

    assert_out_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_tp |=> !div_out);

    assert_out_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_out) |-> $past(carry_tp));

    assert_band_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_sync |=> $stable(band_n));
endmodule

bind dsd_synth_div dsd_checker #(
    .RATIO_W (RATIO_W),
    .BAND_W  (BAND_W),
    .PRE_W   (PRE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .carry_tp (carry_tp),
    .div_out  (div_out),
    .band_n   (band_n),
    .en_sync  (en_sync)
);

// File: tb/tb_dsd_synth_div.sv
module tb_dsd_synth_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b1;
    logic       ser_en = 1'b0;
    logic       div_out;
    logic       carry_tp;
    logic [2:0] band_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int gap_cnt = 0;
    int hi_cnt = 0;
    int last_gap = 0;
    int last_hi = 0;
    int ncarry = 0;
    int wide = 0;
    bit prev_c = 1'b0;

    dsd_synth_div dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_en   (ser_en),
        .div_out  (div_out),
        .carry_tp (carry_tp),
        .band_n   (band_n)
    );

    always #5 clk = ~clk;

    // Period monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            gap_cnt = 0; hi_cnt = 0; prev_c = 1'b0;
        end else begin
            gap_cnt++;
            if (div_out) hi_cnt++;
            if (carry_tp) begin
                if (prev_c) wide++;
                last_gap = gap_cnt; last_hi = hi_cnt;
                gap_cnt = 0; hi_cnt = 0; ncarry++;
            end
            prev_c = carry_tp;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc == 195000) begin
            failures++;
            $display("FAIL watchdog R5 actual=%0d expected=<%0d", cyc, 195000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_carries(input int k);
        int target = ncarry + k;
        wait (ncarry >= target);
    endtask

    function automatic logic [15:0] mk_word(input int n, input logic [2:0] band);
        logic [12:0] nn = 13'(n);
        return {band, ~nn};
    endfunction

    task automatic en_set(input logic v);
        @(negedge clk); ser_en = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) begin
            ser_data = w[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
        end
    endtask

    task automatic load(input int n, input logic [2:0] band);
        en_set(1'b1);
        shift_bits(mk_word(n, band), 0, 15);
        en_set(1'b0);
    endtask

    task automatic measure(input int exp_n, input string tag);
        wait_carries(3);
        chk(last_gap == exp_n, {tag, " period"}, last_gap, exp_n);
        chk(last_hi == 16, "R6 div_out high width", last_hi, 16);
    endtask

    task automatic t_reset();
        chk(band_n == 3'b111, "R1 band_n after reset", band_n, 7);
        measure(256, "R1 reset ratio");
    endtask

    task automatic t_ratio(input int n, input logic [2:0] band, input int exp_n, input string tag);
        load(n, band);
        chk(band_n == ~band, "R9 band_n after load", band_n, int'(~band));
        measure(exp_n, tag);
    endtask

    task automatic t_en_low_ignored();
        logic [15:0] w = mk_word(3000, 3'b010);
        shift_bits(w, 0, 15);
        repeat (6) @(negedge clk);
        chk(band_n == 3'b010, "R3 band_n unchanged", band_n, 2);
        measure(1000, "R3 ratio unchanged");
    endtask

    task automatic t_partial();
        logic [15:0] w = mk_word(2000, 3'b011);
        en_set(1'b1);
        shift_bits(w, 0, 7);
        measure(1000, "R4 ratio held mid-word");
        chk(band_n == 3'b010, "R4 band_n held mid-word", band_n, 2);
        shift_bits(w, 8, 15);
        en_set(1'b0);
        chk(band_n == 3'b100, "R2 band_n after split word", band_n, 4);
        measure(2000, "R2 split word ratio");
    endtask

    task automatic t_midcycle();
        load(300, 3'b001);
        measure(300, "R7 old ratio");
        en_set(1'b1);
        shift_bits(mk_word(5000, 3'b001), 0, 15);
        wait_carries(1);
        repeat (20) @(negedge clk);
        ser_en = 1'b0;
        wait_carries(1);
        chk(last_gap == 300, "R7 period in progress keeps old ratio", last_gap, 300);
        wait_carries(1);
        chk(last_gap == 5000, "R7 next period uses new ratio", last_gap, 5000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ratio(256, 3'b001, 256, "R5 ratio 256");
        t_ratio(257, 3'b010, 257, "R5 ratio 257");
        t_ratio(271, 3'b100, 271, "R5 ratio 271");
        t_ratio(8191, 3'b111, 8191, "R5 ratio 8191");
        t_ratio(100, 3'b000, 256, "R8 clamp 100");
        t_ratio(255, 3'b011, 256, "R8 clamp 255");
        t_ratio(1000, 3'b101, 1000, "R2 ratio 1000");
        t_en_low_ignored();
        t_partial();
        t_midcycle();
        chk(wide == 0, "R10 carry wider than one cycle", wide, 0);
        chk(ncarry > 0, "R10 carry seen", ncarry, 1);
        summary();
        $finish;
    end
endmodule